// File: doc/BRIEF.md
# Byte Serial Port Controller with Select-Line Fault Detection

This block moves bytes over a four-wire synchronous serial link. It acts as the clock-driving end (master) or as the clocked end (slave), and it sits behind a small register bus with three addresses. A single data address is split in two. Writes go into a transmit holding byte. Reads return a receive holding byte. These two bytes are separate storage.

As master, the block divides the bus clock by one of four fixed ratios to make the serial clock, and it runs one byte whenever the transmit byte is full. As slave, it brings the external serial clock and select into the bus clock domain through two flops each. It shifts only while select is low. An enable bit for fault detection decides what a low select does to a master. With the bit set, a low select turns the master into a disabled slave and raises a fault flag. A slave raises the same flag when select is released in the middle of a byte.

Top module: `spi_port`

## Requirements
- R1: The data address (0) is split. A write loads the transmit byte. A read returns the receive byte. Writing the data address never changes what a read of it returns.
- R2: Control register (address 1) bits 1:0 select the rate. The serial clock has a period of 2, 8, 32 or 128 bus clocks for codes 0, 1, 2 and 3. Each high phase therefore lasts 1, 4, 16 or 64 bus clocks.
- R3: Bits move most significant first. The serial clock idles low. The output changes after a falling edge and the input is sampled on a rising edge. One master byte exchanges the transmit byte with the receive byte.
- R4: A master byte starts only when control bit 4 (enable) is 1, control bit 3 (master) is 1 and the transmit byte is full. Otherwise the serial clock stays low and the transmit byte stays full.
- R5: Status register (address 2) bit 1 is transmit-empty. It sets when the transmit byte moves into the shifter and clears on a data write. Bit 0 is receive-full. It sets after eight bits and clears on a data read.
- R6: Reset clears the control register (rate bits included) and sets status to 0x02. The transmit and receive bytes keep their contents through reset.
- R7: With control bit 2 (fault enable) at 1, a low select on an enabled master sets status bit 2, clears the enable and master bits, and keeps the fault-enable bit.
- R8: With fault enable at 0, the select level has no effect on an enabled master. Its byte completes and the control register does not change.
- R9: An enabled slave shifts on the external serial clock while select is low. It sends the transmit byte and stores the received byte. The rate bits have no effect in slave mode.
- R10: An enabled slave ignores serial clock edges while select is high.
- R11: With fault enable at 1, an enabled slave sets status bit 2 when select rises in the middle of a byte. With fault enable at 0, the fault flag never sets.
- R12: Writing 1 to status bit 2 clears the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a data read clears receive-full) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | High while the block is an enabled master |
| sck_i | input | 1 | External serial clock used in slave mode |
| ss_n_i | input | 1 | Active-low select input |
| sdo | output | 1 | Serial data out (master out or slave out) |
| sdi | input | 1 | Serial data in (master in or slave in) |

## Verification
Suppose the bit counter or the phase register is wrong. A byte then finishes a different number of half-periods after it starts, or it lands shifted. The next read of the data address returns a rotated value, and the far end captures a different byte, within one byte time. An error in the rate divider shows up in the first high phase of the serial clock. Errors in the fault or flag logic show up in the control and status readback a few bus clocks after the select change or the bus access that triggers them.

// File: rtl/spi_port_pkg.sv
// Package: shared constants and the rate table for the serial port.
// Assumes an 8-bit data path and a two-bit rate code.
package spi_port_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int DIV_CNT_W = 7;

    localparam logic [ADDR_W-1:0] A_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    // Bus clocks per serial clock half-period, minus one.
    function automatic logic [DIV_CNT_W-1:0] half_minus_one(input logic [1:0] code);
        logic [DIV_CNT_W-1:0] v;
        case (code)
            2'd0:    v = 7'd0;
            2'd1:    v = 7'd3;
            2'd2:    v = 7'd15;
            default: v = 7'd63;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/spi_rate_div.sv
// Module: half-period tick generator for the master serial clock.
// Assumes run is held high for a whole byte; the count restarts when run drops.
module spi_rate_div
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    logic [DIV_CNT_W-1:0] cnt_q;
    logic [DIV_CNT_W-1:0] limit;

    assign limit = half_minus_one(rate);
    assign tick  = run && (cnt_q >= limit);

    // Count bus clocks within one half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Two ticks in a row occur only at the fastest rate.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && rate != 2'b00) |=> (!tick || !$stable(rate)));

endmodule

// File: rtl/spi_in_sync.sv
// Module: multi-flop synchronizer for one asynchronous input.
// Gives the synced level and a one-cycle delayed copy, so edges can be found.
module spi_in_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q,
    output logic q_d
);

    logic [STAGES-1:0] pipe_q;
    logic              last_q;

    // Move the input through the flop chain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
            last_q <= RST_VAL;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_in};
            last_q <= pipe_q[STAGES-1];
        end
    end

    assign q   = pipe_q[STAGES-1];
    assign q_d = last_q;

endmodule

// File: rtl/spi_shift_core.sv
// Module: shared shift engine for both roles. MSB goes out first.
// rise samples the input bit and fall shifts it in. load has priority over fall.
// Data storage is not reset, on purpose.
module spi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         clr,
    input  logic         rise,
    input  logic         fall,
    input  logic         sin,
    output logic         sout,
    output logic         done,
    output logic         mid_byte,
    output logic [W-1:0] rx_byte
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh_q;
    logic          smp_q;
    logic [CW-1:0] cnt_q;

    // Shift register and sampled input bit (data path, no reset).
    always_ff @(posedge clk) begin
        if (load) begin
            sh_q <= load_data;
        end else if (fall) begin
            sh_q <= {sh_q[W-2:0], smp_q};
        end
        if (rise) begin
            smp_q <= sin;
        end
    end

    // Count the bits completed within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) begin
            cnt_q <= '0;
        end else if (fall) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sout     = sh_q[W-1];
    assign done     = fall && (cnt_q == LAST);
    assign mid_byte = (cnt_q != '0);
    assign rx_byte  = {sh_q[W-2:0], smp_q};

    // After a byte ends, the next byte starts counting from zero.
    p_wrap_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mid_byte);

endmodule

// File: rtl/spi_port.sv
// Module: top of the serial port. It holds the register file, the master
// clock engine, the slave edge path and the fault detection.
// Assumes bus_rdata is sampled combinationally while bus_addr is stable.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    input  logic              ss_n_i,
    output logic              sdo,
    input  logic              sdi
);

    // Control and status state.
    logic              en_q, master_q, mfen_q;
    logic [1:0]        rate_q;
    logic              rx_full_q, tx_empty_q, fault_q;
    logic [DATA_W-1:0] tx_buf_q, rx_buf_q;

    // Engine state.
    logic busy_q, sck_q, tick;
    logic sck_s, sck_s_d, ss_s, ss_s_d;
    logic core_load, core_clr, core_rise, core_fall;
    logic core_done, core_mid;
    logic [DATA_W-1:0] core_rx;

    logic wr_data, wr_ctrl, wr_stat, rd_data;
    logic m_active, s_active, s_sel, m_start, m_rise, m_fall;
    logic s_rise, s_fall, ss_rise, ss_fall, s_load;
    logic m_fault, s_fault;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STATUS);
    assign rd_data = bus_rd && (bus_addr == A_DATA);

    assign m_active = en_q && master_q;
    assign s_active = en_q && !master_q;

    spi_rate_div u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_q),
        .rate (rate_q),
        .tick (tick)
    );

    spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (sck_i),
        .q    (sck_s),
        .q_d  (sck_s_d)
    );

    spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (ss_n_i),
        .q    (ss_s),
        .q_d  (ss_s_d)
    );

    // Master side: start condition and edges that follow the divider ticks.
    assign m_start = m_active && !busy_q && !tx_empty_q;
    assign m_rise  = busy_q && tick && !sck_q;
    assign m_fall  = busy_q && tick && sck_q;

    // Slave side: edges count only while select is low.
    assign s_sel   = s_active && !ss_s;
    assign s_rise  = s_sel && sck_s && !sck_s_d;
    assign s_fall  = s_sel && !sck_s && sck_s_d;
    assign ss_fall = !ss_s && ss_s_d;
    assign ss_rise = ss_s && !ss_s_d;
    assign s_load  = s_active && (ss_fall || core_done);

    // Fault sources.
    assign m_fault = m_active && mfen_q && !ss_s;
    assign s_fault = s_active && mfen_q && ss_rise && core_mid;

    assign core_load = m_start || s_load;
    assign core_clr  = en_q ? (!master_q && ss_s) : 1'b1;
    assign core_rise = master_q ? m_rise : s_rise;
    assign core_fall = master_q ? m_fall : s_fall;

    spi_shift_core #(.W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (core_load),
        .load_data(tx_buf_q),
        .clr      (core_clr),
        .rise     (core_rise),
        .fall     (core_fall),
        .sin      (sdi),
        .sout     (sdo),
        .done     (core_done),
        .mid_byte (core_mid),
        .rx_byte  (core_rx)
    );

    // Master clock engine: busy flag and serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || m_fault || !m_active) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
        end else if (m_start) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
        end else if (busy_q && tick) begin
            sck_q <= !sck_q;
            if (core_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Control register; a master fault overrides a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            master_q <= 1'b0;
            mfen_q   <= 1'b0;
            rate_q   <= 2'b00;
        end else begin
            if (wr_ctrl) begin
                en_q     <= bus_wdata[4];
                master_q <= bus_wdata[3];
                mfen_q   <= bus_wdata[2];
                rate_q   <= bus_wdata[1:0];
            end
            if (m_fault) begin
                en_q     <= 1'b0;
                master_q <= 1'b0;
            end
        end
    end

    // Status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full_q  <= 1'b0;
            tx_empty_q <= 1'b1;
            fault_q    <= 1'b0;
        end else begin
            if (core_done) begin
                rx_full_q <= 1'b1;
            end else if (rd_data) begin
                rx_full_q <= 1'b0;
            end
            if (wr_data) begin
                tx_empty_q <= 1'b0;
            end else if (core_load) begin
                tx_empty_q <= 1'b1;
            end
            if (m_fault || s_fault) begin
                fault_q <= 1'b1;
            end else if (wr_stat && bus_wdata[2]) begin
                fault_q <= 1'b0;
            end
        end
    end

    // Data bytes: these keep their contents through reset.
    always_ff @(posedge clk) begin
        if (wr_data) begin
            tx_buf_q <= bus_wdata;
        end
        if (core_done) begin
            rx_buf_q <= core_rx;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_DATA:   bus_rdata = rx_buf_q;
            A_CTRL:   bus_rdata = {3'b000, en_q, master_q, mfen_q, rate_q};
            A_STATUS: bus_rdata = {5'b00000, fault_q, tx_empty_q, rx_full_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign sck_o  = sck_q;
    assign sck_oe = m_active;

    p_fault_demotes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_q) && $past(master_q)) |-> (!en_q && !master_q));

    p_fault_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(mfen_q));

    p_rx_full_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> rx_full_q);

    p_tx_empty_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_load && !wr_data) |=> tx_empty_q);

    p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !m_active |=> !sck_o);

endmodule

// File: tb/spi_port_tb.sv
// Bench: a vector table of master bytes, then directed tests for reset,
// faults and slave operation.
module spi_port_tb_top;
    import spi_port_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       sck_o, sck_oe, sck_i, ss_n_i, sdo, sdi;

    logic       use_slave, sdi_b, ld_pulse;
    logic [7:0] ext_val, ext_sh, cap;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .ss_n_i(ss_n_i),
        .sdo(sdo), .sdi(sdi)
    );

    // Model of the far-end device when the block is master.
    always @(negedge sck_o or posedge ld_pulse) begin
        if (ld_pulse) ext_sh <= ext_val;
        else          ext_sh <= {ext_sh[6:0], 1'b0};
    end
    always @(posedge sck_o) cap <= {cap[6:0], sdo};

    assign sdi = use_slave ? sdi_b : ext_sh[7];

    // Vector layout: {rate, tx byte, far-end byte}.
    localparam logic [17:0] VEC [0:4] = '{
        {2'b00, 8'hA5, 8'h3C},
        {2'b01, 8'h0F, 8'hF0},
        {2'b10, 8'h81, 8'h7E},
        {2'b11, 8'h5A, 8'hC3},
        {2'b00, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load_ext(input logic [7:0] v);
        @(negedge clk);
        ext_val = v; ld_pulse = 1'b1;
        #1 ld_pulse = 1'b0;
    endtask

    // Wait for receive-full and note the length of the first serial clock high phase.
    task automatic wait_rx(output int first_hi);
        int hi = 0;
        bit got = 0;
        first_hi = -1;
        bus_addr = A_STATUS;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            bus_addr = A_STATUS;
            #1;
            if (sck_o) hi++;
            else begin
                if (hi > 0 && first_hi < 0) first_hi = hi;
                hi = 0;
            end
            if (bus_rdata[0]) begin got = 1; break; end
        end
        if (!got) chk("R5 receive-full timeout", 0, 1);
    endtask

    task automatic slave_xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = 8'h00;
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi_b = mo[7-i];
            repeat (6) @(negedge clk);
            mi = {mi[6:0], sdo};
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] rd, mi;
        int hi;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        sck_i = 0; ss_n_i = 1; use_slave = 0; sdi_b = 0; ld_pulse = 0; ext_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: state after reset
        bus_read(A_CTRL, rd);   chk("R6 control after reset", rd, 8'h00);
        bus_read(A_STATUS, rd); chk("R6 status after reset", rd, 8'h02);

        // R4: master bit set but not enabled, so nothing starts
        bus_write(A_CTRL, 8'h08);
        load_ext(8'h66);
        bus_write(A_DATA, 8'h99);
        repeat (40) @(negedge clk);
        bus_read(A_STATUS, rd); chk("R4/R5 held while disabled", rd, 8'h00);
        chk("R4 clock idle", sck_o, 1'b0);
        bus_write(A_CTRL, 8'h18);
        wait_rx(hi);
        bus_read(A_DATA, rd); chk("R4 byte after enable", rd, 8'h66);
        chk("R3 far end captured", cap, 8'h99);

        // R2 R3 R5: the vector table
        for (int v = 0; v < 5; v++) begin
            logic [1:0] rt;
            logic [7:0] tx, ex;
            {rt, tx, ex} = VEC[v];
            bus_write(A_CTRL, {6'b000110, rt});
            load_ext(ex);
            bus_write(A_DATA, tx);
            wait_rx(hi);
            chk("R2 high phase length", hi, 32'(1 << (2 * rt)));
            bus_read(A_DATA, rd); chk("R3 received byte", rd, ex);
            chk("R3 far end captured", cap, tx);
            bus_read(A_STATUS, rd); chk("R5 flags after data read", rd, 8'h02);
        end

        // R1: a data write does not change what a data read returns
        bus_write(A_CTRL, 8'h00);
        bus_write(A_DATA, 8'h3C);
        bus_read(A_DATA, rd); chk("R1 split data address", rd, 8'h00);

        // R6: data bytes survive reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_read(A_DATA, rd);   chk("R6 receive byte kept", rd, 8'h00);
        bus_read(A_STATUS, rd); chk("R6 status after second reset", rd, 8'h02);

        // R8: fault enable off, a low select does not stop the master
        ss_n_i = 1'b0;
        bus_write(A_CTRL, 8'h19);
        load_ext(8'hB4);
        bus_write(A_DATA, 8'h2E);
        wait_rx(hi);
        bus_read(A_CTRL, rd);   chk("R8 control unchanged", rd, 8'h19);
        bus_read(A_DATA, rd);   chk("R8 byte completes", rd, 8'hB4);
        bus_read(A_STATUS, rd); chk("R8 no fault", rd[2], 1'b0);

        // R7: fault enable on, a low select demotes the master
        bus_write(A_CTRL, 8'h1C);
        repeat (4) @(negedge clk);
        bus_read(A_CTRL, rd);   chk("R7 control after fault", rd, 8'h04);
        bus_read(A_STATUS, rd); chk("R7 fault flag", rd[2], 1'b1);
        chk("R7 clock not driven", sck_oe, 1'b0);
        bus_write(A_STATUS, 8'h04);
        bus_read(A_STATUS, rd); chk("R12 fault cleared", rd[2], 1'b0);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);

        // R9: slave at two rate codes
        use_slave = 1'b1;
        bus_write(A_CTRL, 8'h13);
        bus_write(A_DATA, 8'h96);
        slave_xfer(8'h5B, 8, mi);
        chk("R9 slave sent byte", mi, 8'h96);
        bus_read(A_DATA, rd);   chk("R9 slave received", rd, 8'h5B);
        bus_read(A_STATUS, rd); chk("R9 status after read", rd, 8'h02);
        bus_write(A_CTRL, 8'h10);
        bus_write(A_DATA, 8'h4E);
        slave_xfer(8'hC3, 8, mi);
        chk("R9 slave sent at rate 0", mi, 8'h4E);
        bus_read(A_DATA, rd); chk("R9 slave received at rate 0", rd, 8'hC3);

        // R10: clock edges with select high are ignored
        bus_write(A_DATA, 8'h71);
        for (int k = 0; k < 8; k++) begin
            repeat (6) @(negedge clk); sck_i = 1'b1;
            repeat (6) @(negedge clk); sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        bus_read(A_STATUS, rd); chk("R10 no activity with select high", rd, 8'h00);
        slave_xfer(8'h2D, 8, mi);
        chk("R10 next byte sent intact", mi, 8'h71);
        bus_read(A_DATA, rd); chk("R10 next byte received intact", rd, 8'h2D);

        // R11: select released in the middle of a byte
        bus_write(A_CTRL, 8'h14);
        slave_xfer(8'h12, 3, mi);
        bus_read(A_STATUS, rd); chk("R11 slave fault set", rd[2], 1'b1);
        bus_write(A_STATUS, 8'h04);
        bus_read(A_STATUS, rd); chk("R12 fault cleared again", rd[2], 1'b0);
        bus_write(A_CTRL, 8'h10);
        slave_xfer(8'h12, 3, mi);
        bus_read(A_STATUS, rd); chk("R11 no fault when disabled", rd[2], 1'b0);
        chk("R11 no byte from partial", rd[0], 1'b0);

        finish_run();
    end

endmodule